// File: doc/BRIEF.md
# Programmable Address-Decoded Chip Select

This block drives the chip-select lines of an 8-bit microcontroller's external bus. There are four selects: one for I/O devices, two general-purpose ones and one for program memory. Each is worked out from the current bus address. The general-purpose selects can decode either the 16-bit CPU address or a 19-bit expanded address. That choice is made per select, and so are the base address, the range size, the output polarity and the number of wait cycles the select adds to an access.

The configuration arrives on plain input ports that hold the register contents. The address-window logic supplies two "window hit" flags and the memory map supplies one "on-chip hit" flag. On every valid bus cycle the block chooses at most one winning select by fixed priority and drives the select pins. It also holds a stretch request towards the bus controller for the winner's programmed number of extra cycles. A merge control can combine general-purpose select 2 with the program select on the program pin.

Top module: `bus_chip_select`

## Requirements
- R1: While rst_ni is low, or while cycle_valid_i is low, or in the first cycle after reset is released, every select pin sits at its inactive level and stretch_o is 0. The inactive level is the inverse of the select's polarity input.
- R2: The I/O select hits when io_en_i is 1 and cpu_addr_i[15:12] equals 4'h1. Its pin is active low when io_pol_i is 0 and active high when io_pol_i is 1. With io_en_i at 0 it never becomes active.
- R3: A general-purpose size code c in 1..8 compares address bits 18 down to 10+c with base bits 7 down to c-1. Code 1 covers a 2 KB range and each later code doubles it, up to code 8, which covers 256 KB and compares bit 18 only. Code 9 matches any address (512 KB).
- R4: Size code 10 hits exactly when win1_hit_i is 1, and code 11 exactly when win2_hit_i is 1. Codes 0 and 12 to 15 disable the select.
- R5: A general-purpose select with gp_exp_i[k]=1 decodes exp_addr_i. With gp_exp_i[k]=0 it decodes cpu_addr_i zero-extended to 19 bits.
- R6: onchip_hit_i=1 keeps every select inactive and gives no stretch.
- R7: At most one select wins. The I/O select beats the general-purpose selects, and they beat the program select. Between the two general-purpose selects, gp_prio_i=0 lets select 1 (index 0) win and gp_prio_i=1 lets select 2 (index 1) win.
- R8: The program select hits when prog_en_i is 1 and cpu_addr_i[15] is 1.
- R9: With merge_i=1 the program pin is also active whenever general-purpose select 2 wins. With merge_i=0 the program pin shows only the program select.
- R10: When addr_strobe_i is 1 in a valid cycle with a winner whose 2-bit stretch value is n, stretch_o is 1 for exactly n cycles, starting in the strobe cycle. When n is 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_valid_i | input | 1 | Bus cycle in progress with a valid address |
| addr_strobe_i | input | 1 | First cycle of a new bus cycle |
| cpu_addr_i | input | 16 | CPU address |
| exp_addr_i | input | 19 | Expanded address |
| onchip_hit_i | input | 1 | Address maps to an on-chip resource |
| win1_hit_i | input | 1 | Address lies in expansion window 1 |
| win2_hit_i | input | 1 | Address lies in expansion window 2 |
| io_en_i | input | 1 | I/O select enable |
| io_pol_i | input | 1 | I/O select polarity (1 = active high) |
| io_str_i | input | 2 | I/O select stretch cycles |
| gp_base_i | input | 2x8 | General-purpose base, address bits 18:11 |
| gp_size_i | input | 2x4 | General-purpose size code |
| gp_exp_i | input | 2 | General-purpose decode basis (1 = expanded) |
| gp_pol_i | input | 2 | General-purpose polarity |
| gp_str_i | input | 2x2 | General-purpose stretch cycles |
| gp_prio_i | input | 1 | Overlap winner (0 = select 1, 1 = select 2) |
| prog_en_i | input | 1 | Program select enable |
| prog_pol_i | input | 1 | Program select polarity |
| prog_str_i | input | 2 | Program select stretch cycles |
| merge_i | input | 1 | OR general-purpose select 2 onto the program pin |
| cs_io_o | output | 1 | I/O select pin |
| cs_gp_o | output | 2 | General-purpose select pins |
| cs_prog_o | output | 1 | Program select pin |
| stretch_o | output | 1 | Wait-cycle request to the bus controller |

## Verification
The hardest cases to reach are the range edges of the larger size codes and three-way overlaps. In these the I/O, a general-purpose and the program select all hit together, and the answer depends on both the priority bit and the merge control. Directed transactions place the address one step inside and one step outside each compared boundary. They also stack the selects on the same address in every priority order. A stream of random configurations and addresses, checked against an independent shift-based model, then covers the mixtures the directed cases miss.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned NUM_GP  = 2;
  localparam int unsigned NUM_SEL = NUM_GP + 2;

  typedef enum int unsigned {
    SEL_IO   = 0,
    SEL_GP1  = 1,
    SEL_GP2  = 2,
    SEL_PROG = 3
  } sel_idx_e;
endpackage

// File: rtl/cs_range_match.sv
module cs_range_match #(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned EXP_AW = 19,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned SIZE_W = 4
) (
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [EXP_AW-1:0] exp_addr_i,
  input  logic              use_exp_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              win1_hit_i,
  input  logic              win2_hit_i,
  output logic              hit_o
);
  localparam int unsigned LOW_BIT  = EXP_AW - BASE_W;
  localparam int unsigned CODE_ALL = BASE_W + 1;
  localparam int unsigned CODE_W1  = BASE_W + 2;
  localparam int unsigned CODE_W2  = BASE_W + 3;

  logic [EXP_AW-1:0] addr;
  logic [BASE_W-1:0] top_bits;
  logic [BASE_W-1:0] cmp_mask;
  int unsigned       code;

  always_comb begin
    addr     = use_exp_i ? exp_addr_i : EXP_AW'(cpu_addr_i);
    top_bits = addr[EXP_AW-1:LOW_BIT];
    code     = int'(size_i);
    // larger range code -> fewer low base bits compared
    for (int i = 0; i < int'(BASE_W); i++)
      cmp_mask[i] = (code != 0) && (i + 1 >= int'(code));
  end

  always_comb begin
    if (code == 0)             hit_o = 1'b0;
    else if (code <= BASE_W)   hit_o = ((top_bits ^ base_i) & cmp_mask) == '0;
    else if (code == CODE_ALL) hit_o = 1'b1;
    else if (code == CODE_W1)  hit_o = win1_hit_i;
    else if (code == CODE_W2)  hit_o = win2_hit_i;
    else                       hit_o = 1'b0;
  end
endmodule

// File: rtl/cs_arbiter.sv
module cs_arbiter
  import cs_pkg::*;
(
  input  logic [NUM_SEL-1:0] req_i,
  input  logic               onchip_i,
  input  logic               gp_prio_i,
  output logic [NUM_SEL-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    if (!onchip_i) begin
      if (req_i[SEL_IO])                    gnt_o[SEL_IO]   = 1'b1;
      else if (gp_prio_i && req_i[SEL_GP2]) gnt_o[SEL_GP2]  = 1'b1;
      else if (req_i[SEL_GP1])              gnt_o[SEL_GP1]  = 1'b1;
      else if (req_i[SEL_GP2])              gnt_o[SEL_GP2]  = 1'b1;
      else if (req_i[SEL_PROG])             gnt_o[SEL_PROG] = 1'b1;
    end
  end
endmodule

// File: rtl/cs_stretch.sv
module cs_stretch #(
  parameter int unsigned STR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [STR_W-1:0] len_i,
  output logic             stretch_o
);
  logic [STR_W-1:0] cnt_q;

  assign stretch_o = (cnt_q != '0) || (start_i && (len_i != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  AST_NO_STRETCH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i == '0) |-> (stretch_o == (cnt_q != '0)))
    else $error("zero stretch raised request"); // R10
  AST_STRETCH_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stretch_o) |-> start_i)
    else $error("stretch began without strobe"); // R10
  AST_STRETCH_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q == '0) |-> !stretch_o)
    else $error("stretch held past count"); // R10
endmodule

// File: rtl/bus_chip_select.sv
module bus_chip_select
  import cs_pkg::*;
#(
  parameter int unsigned CPU_AW    = 16,
  parameter int unsigned EXP_AW    = 19,
  parameter int unsigned BASE_W    = 8,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned STR_W     = 2,
  parameter int unsigned IO_HI_W   = 4,
  parameter logic [IO_HI_W-1:0]   IO_PAGE   = 4'h1,
  parameter int unsigned PROG_HI_W = 1,
  parameter logic [PROG_HI_W-1:0] PROG_PAGE = 1'b1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cycle_valid_i,
  input  logic                            addr_strobe_i,
  input  logic [CPU_AW-1:0]               cpu_addr_i,
  input  logic [EXP_AW-1:0]               exp_addr_i,
  input  logic                            onchip_hit_i,
  input  logic                            win1_hit_i,
  input  logic                            win2_hit_i,
  input  logic                            io_en_i,
  input  logic                            io_pol_i,
  input  logic [STR_W-1:0]                io_str_i,
  input  logic [NUM_GP-1:0][BASE_W-1:0]   gp_base_i,
  input  logic [NUM_GP-1:0][SIZE_W-1:0]   gp_size_i,
  input  logic [NUM_GP-1:0]               gp_exp_i,
  input  logic [NUM_GP-1:0]               gp_pol_i,
  input  logic [NUM_GP-1:0][STR_W-1:0]    gp_str_i,
  input  logic                            gp_prio_i,
  input  logic                            prog_en_i,
  input  logic                            prog_pol_i,
  input  logic [STR_W-1:0]                prog_str_i,
  input  logic                            merge_i,
  output logic                            cs_io_o,
  output logic [NUM_GP-1:0]               cs_gp_o,
  output logic                            cs_prog_o,
  output logic                            stretch_o
);
  logic               run_q;
  logic               active;
  logic [NUM_GP-1:0]  gp_hit;
  logic               io_hit;
  logic               prog_hit;
  logic [NUM_SEL-1:0] req;
  logic [NUM_SEL-1:0] gnt;
  logic [STR_W-1:0]   win_len;
  logic               prog_act;

  // selects stay quiet for the first cycle out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign active   = run_q && cycle_valid_i;
  assign io_hit   = io_en_i && (cpu_addr_i[CPU_AW-1 -: IO_HI_W] == IO_PAGE);
  assign prog_hit = prog_en_i && (cpu_addr_i[CPU_AW-1 -: PROG_HI_W] == PROG_PAGE);

  for (genvar k = 0; k < NUM_GP; k++) begin : g_gp
    cs_range_match #(
      .CPU_AW(CPU_AW), .EXP_AW(EXP_AW), .BASE_W(BASE_W), .SIZE_W(SIZE_W)
    ) u_match (
      .cpu_addr_i (cpu_addr_i),
      .exp_addr_i (exp_addr_i),
      .use_exp_i  (gp_exp_i[k]),
      .base_i     (gp_base_i[k]),
      .size_i     (gp_size_i[k]),
      .win1_hit_i (win1_hit_i),
      .win2_hit_i (win2_hit_i),
      .hit_o      (gp_hit[k])
    );
  end

  always_comb begin
    req           = '0;
    req[SEL_IO]   = active && io_hit;
    req[SEL_GP1]  = active && gp_hit[0];
    req[SEL_GP2]  = active && gp_hit[1];
    req[SEL_PROG] = active && prog_hit;
  end

  cs_arbiter u_arb (
    .req_i     (req),
    .onchip_i  (onchip_hit_i),
    .gp_prio_i (gp_prio_i),
    .gnt_o     (gnt)
  );

  always_comb begin
    win_len = '0;
    if (gnt[SEL_IO])   win_len = io_str_i;
    if (gnt[SEL_GP1])  win_len = gp_str_i[0];
    if (gnt[SEL_GP2])  win_len = gp_str_i[1];
    if (gnt[SEL_PROG]) win_len = prog_str_i;
  end

  cs_stretch #(.STR_W(STR_W)) u_str (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (addr_strobe_i && active),
    .len_i     (win_len),
    .stretch_o (stretch_o)
  );

  assign prog_act   = gnt[SEL_PROG] || (merge_i && gnt[SEL_GP2]);
  assign cs_io_o    = io_pol_i ? gnt[SEL_IO] : !gnt[SEL_IO];
  assign cs_gp_o[0] = gp_pol_i[0] ? gnt[SEL_GP1] : !gnt[SEL_GP1];
  assign cs_gp_o[1] = gp_pol_i[1] ? gnt[SEL_GP2] : !gnt[SEL_GP2];
  assign cs_prog_o  = prog_pol_i ? prog_act : !prog_act;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_valid_i |-> (cs_io_o != io_pol_i && cs_gp_o == ~gp_pol_i
                        && cs_prog_o != prog_pol_i))
    else $error("select active outside bus cycle"); // R1
  AST_ONCHIP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    onchip_hit_i |-> (cs_io_o != io_pol_i && cs_gp_o == ~gp_pol_i
                      && cs_prog_o != prog_pol_i))
    else $error("external select beat on-chip resource"); // R6
  AST_SINGLE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt))
    else $error("more than one select granted"); // R7
  AST_MERGE_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (merge_i && cs_gp_o[1] == gp_pol_i[1]) |-> (cs_prog_o == prog_pol_i))
    else $error("merged program pin missed select 2"); // R9
endmodule

// File: tb/sim_bus_chip_select.sv
module sim_bus_chip_select;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        valid, strobe, onchip, win1, win2;
  logic [15:0] cpu;
  logic [18:0] exa;
  logic        io_en, io_pol, gp_prio, prog_en, prog_pol, merge;
  logic [1:0]  io_str, prog_str;
  logic [1:0][7:0] gp_base;
  logic [1:0][3:0] gp_size;
  logic [1:0]      gp_exp, gp_pol;
  logic [1:0][1:0] gp_str;
  logic        cs_io, cs_prog, stretch;
  logic [1:0]  cs_gp;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bus_chip_select u0 (
    .clk_i(clk), .rst_ni(rst_n), .cycle_valid_i(valid), .addr_strobe_i(strobe),
    .cpu_addr_i(cpu), .exp_addr_i(exa), .onchip_hit_i(onchip),
    .win1_hit_i(win1), .win2_hit_i(win2),
    .io_en_i(io_en), .io_pol_i(io_pol), .io_str_i(io_str),
    .gp_base_i(gp_base), .gp_size_i(gp_size), .gp_exp_i(gp_exp),
    .gp_pol_i(gp_pol), .gp_str_i(gp_str), .gp_prio_i(gp_prio),
    .prog_en_i(prog_en), .prog_pol_i(prog_pol), .prog_str_i(prog_str),
    .merge_i(merge), .cs_io_o(cs_io), .cs_gp_o(cs_gp), .cs_prog_o(cs_prog),
    .stretch_o(stretch)
  );

  typedef struct {
    logic [3:0] pins;   // {prog, gp2, gp1, io}
    int         str;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  event txn_ev;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic gp_model(input int k);
    logic [18:0] a;
    int c;
    a = gp_exp[k] ? exa : {3'b000, cpu};
    c = int'(gp_size[k]);
    if (c == 0) return 1'b0;
    if (c <= 8) return ((a[18:11] >> (c - 1)) == (gp_base[k] >> (c - 1)));
    if (c == 9) return 1'b1;
    if (c == 10) return win1;
    if (c == 11) return win2;
    return 1'b0;
  endfunction

  function automatic exp_t model(input string tag);
    exp_t e;
    logic io_h, p_h, g1, g2;
    int win;  // -1 none, 0 io, 1 gp1, 2 gp2, 3 prog
    logic [3:0] act;
    io_h = io_en && cpu[15:12] == 4'h1;
    p_h  = prog_en && cpu[15];
    g1   = gp_model(0);
    g2   = gp_model(1);
    win  = -1;
    if (!onchip) begin
      if (io_h) win = 0;
      else if (gp_prio && g2) win = 2;
      else if (g1) win = 1;
      else if (g2) win = 2;
      else if (p_h) win = 3;
    end
    act    = 4'b0000;
    if (win >= 0) act[win] = 1'b1;
    if (merge && win == 2) act[3] = 1'b1;
    e.pins = {prog_pol ? act[3] : !act[3], gp_pol[1] ? act[2] : !act[2],
              gp_pol[0] ? act[1] : !act[1], io_pol ? act[0] : !act[0]};
    case (win)
      0: e.str = int'(io_str);
      1: e.str = int'(gp_str[0]);
      2: e.str = int'(gp_str[1]);
      3: e.str = int'(prog_str);
      default: e.str = 0;
    endcase
    e.tag = tag;
    return e;
  endfunction

  function automatic logic [3:0] idle_pins();
    return {!prog_pol, !gp_pol[1], !gp_pol[0], !io_pol};
  endfunction

  // driver: one bus cycle of five clocks, then one idle clock
  task automatic run(input logic [15:0] c, input logic [18:0] x, input string tag);
    @(negedge clk);
    cpu = c; exa = x; valid = 1'b1; strobe = 1'b1;
    sb_q.push_back(model(tag));
    -> txn_ev;
    @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
    valid = 1'b0;
    #1;
    check({cs_prog, cs_gp, cs_io} == idle_pins() && !stretch, "R1 idle",
          {stretch, cs_prog, cs_gp, cs_io}, idle_pins());
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      int n;
      @(txn_ev);
      e = sb_q.pop_front();
      #1;
      check({cs_prog, cs_gp, cs_io} == e.pins, e.tag, {cs_prog, cs_gp, cs_io}, e.pins);
      n = int'(stretch);
      repeat (4) begin
        @(negedge clk);
        #1;
        n += int'(stretch);
      end
      check(n == e.str, {e.tag, " R10 stretch"}, n, e.str);
    end
  end

  task automatic cfg_clear();
    io_en = 0; io_pol = 0; io_str = 0; prog_en = 0; prog_pol = 0; prog_str = 0;
    gp_base = '0; gp_size = '0; gp_exp = '0; gp_pol = '0; gp_str = '0;
    gp_prio = 0; merge = 0; onchip = 0; win1 = 0; win2 = 0;
  endtask

  initial begin
    valid = 0; strobe = 0; cpu = 16'h1000; exa = '0;
    cfg_clear();
    io_en = 1; io_pol = 1; valid = 1; strobe = 1;
    repeat (3) @(negedge clk);
    #1;
    check({cs_prog, cs_gp, cs_io} == idle_pins() && !stretch, "R1 reset",
          {stretch, cs_prog, cs_gp, cs_io}, idle_pins());
    rst_n = 1'b1;
    #1;
    check(cs_io == 1'b0, "R1 first cycle after reset", cs_io, 0);
    valid = 0; strobe = 0;
    @(negedge clk);

    // R2: I/O select polarity and enable
    io_en = 1; io_pol = 0; io_str = 2;
    run(16'h1234, '0, "R2 io active low");
    io_pol = 1; io_str = 0;
    run(16'h1FFF, '0, "R2 io active high");
    run(16'h2000, '0, "R2 io outside page");
    io_en = 0;
    run(16'h1000, '0, "R2 io disabled");

    // R3 / R5: base compare by size
    cfg_clear();
    gp_size[0] = 4'd1; gp_base[0] = 8'h01; gp_str[0] = 1;
    run(16'h0800, '0, "R3 R5 2K cpu hit");
    run(16'h1000, '0, "R3 2K miss above");
    gp_exp[0] = 1; gp_size[0] = 4'd3; gp_base[0] = 8'h04; gp_pol[0] = 1;
    run('0, 19'h02345, "R3 8K exp hit");
    run('0, 19'h03FFF, "R3 8K top edge");
    run('0, 19'h04000, "R3 8K past edge");
    run('0, 19'h01FFF, "R3 8K below edge");
    gp_size[0] = 4'd8; gp_base[0] = 8'h80;
    run('0, 19'h40000, "R3 256K hit");
    run('0, 19'h3FFFF, "R3 256K miss");
    gp_size[0] = 4'd9;
    run('0, 19'h12345, "R3 512K any");
    // R5: mode picks address source
    gp_size[0] = 4'd1; gp_base[0] = 8'h20; gp_exp[0] = 0;
    run(16'h0000, 19'h10000, "R5 cpu mode ignores exp addr");
    gp_exp[0] = 1;
    run(16'h0000, 19'h10000, "R5 exp mode");

    // R4: window follow and disable codes
    gp_size[0] = 4'd10; win1 = 1;
    run('0, '0, "R4 follow win1 hit");
    win1 = 0;
    run('0, '0, "R4 follow win1 miss");
    gp_size[0] = 4'd11; win2 = 1;
    run('0, '0, "R4 follow win2 hit");
    gp_size[0] = 4'd0;
    run('0, '0, "R4 code 0 off");
    gp_size[0] = 4'd12;
    run('0, '0, "R4 code 12 off");
    win2 = 0;

    // R8: program select
    cfg_clear();
    prog_en = 1; prog_str = 3;
    run(16'h8000, '0, "R8 prog hit");
    run(16'h7FFF, '0, "R8 prog miss");
    prog_en = 0;
    run(16'h9000, '0, "R8 prog disabled");

    // R6: on-chip override
    prog_en = 1; io_en = 1; gp_size[0] = 4'd9; onchip = 1;
    run(16'h9000, '0, "R6 onchip overrides");
    onchip = 0;

    // R7: priority
    cfg_clear();
    gp_size = {4'd9, 4'd9}; gp_str = {2'd1, 2'd2}; gp_pol = 2'b10;
    run('0, '0, "R7 gp1 wins prio0");
    gp_prio = 1;
    run('0, '0, "R7 gp2 wins prio1");
    io_en = 1; io_str = 3;
    run(16'h1000, '0, "R7 io beats gp");
    io_en = 0; prog_en = 1; gp_size[1] = 4'd0; gp_prio = 0;
    run(16'h8000, '0, "R7 gp beats prog");
    gp_size[0] = 4'd0;
    run(16'h8000, '0, "R7 prog alone");

    // R9: merge
    cfg_clear();
    gp_size[1] = 4'd9; gp_pol[1] = 1; merge = 1; prog_pol = 1;
    run('0, '0, "R9 merged onto prog");
    merge = 0;
    run('0, '0, "R9 unmerged");

    // random mixtures
    for (int i = 0; i < 300; i++) begin
      io_en = 1'($urandom); io_pol = 1'($urandom); io_str = 2'($urandom);
      prog_en = 1'($urandom); prog_pol = 1'($urandom); prog_str = 2'($urandom);
      gp_prio = 1'($urandom); merge = 1'($urandom); onchip = (($urandom % 8) == 0);
      win1 = 1'($urandom); win2 = 1'($urandom);
      for (int k = 0; k < 2; k++) begin
        gp_base[k] = 8'($urandom % 4); gp_size[k] = 4'($urandom);
        gp_exp[k] = 1'($urandom); gp_pol[k] = 1'($urandom); gp_str[k] = 2'($urandom);
      end
      run(16'($urandom), 19'($urandom % 32768), "R3 R7 R9 random");
    end

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule